// File: doc/BRIEF.md
# Audio Codec Master Clock Generator

This block produces the internal master clock of an audio codec and a slower shift clock for a digital microphone. One of two free-running input clocks is picked through a handover that never produces a runt pulse. The picked clock is divided by 1, 2, 3, 4 or 6; the division by 3 keeps its duty cycle near one half. The result passes through a clock gate that can park it low to save power. The gated master clock is divided once more, by 2 or by 4, to give the microphone shift clock.

All settings sit in one 8-bit control register. Its write and read port is clocked by the first input clock, which must always run. A divide code outside the legal set is refused: the previous ratio is kept and a sticky error flag is set. The flag clears only on reset. A valid flag reports that a source is connected and the gate is open.

Top module: `mclk_gen`

## Requirements
- R1: After reset the register reads 0x00, the error flag is 0, the master clock follows the first input undivided, and the shift clock runs at half the master clock rate.
- R2: Register bit 7 selects the shift-clock ratio, bit 4 the source, bits 3..1 the master divide code and bit 0 the gate-off control. Bits 6 and 5 ignore writes and read back as 0.
- R3: A source select of 0 drives the master clock from `clk_a` and 1 from `clk_b`.
- R4: Divide codes 000, 010, 011, 100 and 101 give master-clock periods of 1, 2, 3, 4 and 6 source periods.
- R5: For every legal ratio N, the master clock is high for N/2 source periods, so the ratio 3 output is high for 1.5 source periods.
- R6: A write carrying divide code 001, 110 or 111 leaves the stored code and the running ratio unchanged and sets `cfg_err`, which stays set until reset.
- R7: A shift-clock select of 0 gives a period of 2 master-clock periods, and 1 gives a period of 4 master-clock periods.
- R8: With the gate-off bit set, `mclk_out` stays low and `mclk_valid` is 0. Clearing the bit restores the clock.
- R9: Across source switches, gating and ratio changes made while gated, no high or low phase of `mclk_out` or `shclk_out` is shorter than half the period of the faster input.
- R10: The two source enables are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First source clock; also clocks the register port |
| clk_b | input | 1 | Second source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on rising `clk_a` |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| cfg_err | output | 1 | Sticky flag set by a reserved divide code |
| mclk_out | output | 1 | Gated internal master clock |
| shclk_out | output | 1 | Microphone shift clock |
| mclk_valid | output | 1 | A source is connected and the gate is open |

## Verification
The assertions assume that `wr_en` and `wr_data` change only away from rising `clk_a`, and that both input clocks run freely, so the source handover can finish. The divider and the shift-clock select are not synchronised to the source domain. The runt-free property of R9 therefore holds only if the ratio and the shift-clock select change while the gate is closed. The stimulus follows that rule. It closes the gate with a write that changes nothing else, lets the gate settle, writes the new source, ratio and shift selection, waits for the handover, and only then reopens the gate. A monitor meanwhile measures every phase of both output clocks.

// File: rtl/mclk_gen.sv
module mclk_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cfg_err,
  output logic       mclk_out,
  output logic       shclk_out,
  output logic       mclk_valid
);
  localparam int LAST = SYNC_STAGES - 1;

  function automatic logic code_ok(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic [2:0] ratio_of(input logic [2:0] c);
    case (c)
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd4;
      3'd5:    return 3'd6;
      default: return 3'd1;
    endcase
  endfunction

  logic       shc_sel, src_sel, gate_off, err_q;
  logic [2:0] div_code;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      shc_sel  <= 1'b0;
      src_sel  <= 1'b0;
      gate_off <= 1'b0;
      div_code <= 3'd0;
      err_q    <= 1'b0;
    end else if (wr_en) begin
      shc_sel  <= wr_data[7];
      src_sel  <= wr_data[4];
      gate_off <= wr_data[0];
      if (code_ok(wr_data[3:1])) div_code <= wr_data[3:1];
      else                       err_q    <= 1'b1;
    end

  assign rd_data = {shc_sel, 2'b00, src_sel, div_code, gate_off};
  assign cfg_err = err_q;

  logic [LAST:0] a_sync, b_sync;
  logic          a_en, b_en;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_sync <= '0;
    else        a_sync <= {a_sync[LAST-1:0], ~src_sel & ~b_en};

  always_ff @(negedge clk_a or negedge rst_n)
    if (!rst_n) a_en <= 1'b0;
    else        a_en <= a_sync[LAST];

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_sync <= '0;
    else        b_sync <= {b_sync[LAST-1:0], src_sel & ~a_en};

  always_ff @(negedge clk_b or negedge rst_n)
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= b_sync[LAST];

  logic src_clk;
  assign src_clk = (clk_a & a_en) | (clk_b & b_en);

  logic [2:0] ratio, cnt, cnt_nxt;
  logic       q_pos, q_neg, div_clk;

  assign ratio   = ratio_of(div_code);
  assign cnt_nxt = (cnt >= ratio - 3'd1) ? 3'd0 : cnt + 3'd1;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= 3'd0;
      q_pos <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      q_pos <= cnt_nxt < (ratio >> 1);
    end

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) q_neg <= 1'b0;
    else        q_neg <= q_pos;

  assign div_clk = (ratio == 3'd1) ? src_clk :
                   (ratio == 3'd3) ? (q_pos | q_neg) : q_pos;

  logic gate_en;
  always_latch
    if (!div_clk) gate_en = ~gate_off;

  assign mclk_out   = div_clk & gate_en;
  assign mclk_valid = (a_en | b_en) & gate_en;

  logic [1:0] sc;
  always_ff @(posedge mclk_out or negedge rst_n)
    if (!rst_n) sc <= 2'd0;
    else        sc <= sc + 2'd1;

  assign shclk_out = shc_sel ? sc[1] : sc[0];
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk (
  input logic       clk_a,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       cfg_err,
  input logic       a_en,
  input logic       b_en
);
  logic bad_code;
  assign bad_code = (wr_data[3:1] == 3'd1) || (wr_data[3:1] == 3'd6) || (wr_data[3:1] == 3'd7);

  AST_RSVD_ZERO: assert property (@(posedge clk_a) disable iff (!rst_n) rd_data[6:5] == 2'b00); // R2
  AST_WR_LEGAL: assert property (@(posedge clk_a) disable iff (!rst_n)
    (wr_en && !bad_code) |=> rd_data == {$past(wr_data[7]), 2'b00, $past(wr_data[4:0])}); // R2
  AST_BAD_HOLD: assert property (@(posedge clk_a) disable iff (!rst_n)
    (wr_en && bad_code) |=> (rd_data[3:1] == $past(rd_data[3:1])) && cfg_err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_a) disable iff (!rst_n) cfg_err |=> cfg_err); // R6
  AST_ONE_SOURCE: assert property (@(posedge clk_a) disable iff (!rst_n) !(a_en && b_en)); // R10
endmodule

bind mclk_gen mclk_gen_chk u_chk (
  .clk_a(clk_a), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .cfg_err(cfg_err), .a_en(a_en), .b_en(b_en)
);

// File: tb/mclk_gen_bench.sv
`timescale 1ns/1ps
module mclk_gen_bench;
  localparam real TA = 20.0;
  localparam real TB = 14.0;
  localparam real MINPH = TB / 2.0;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic cfg_err, mclk_out, shclk_out, mclk_valid;

  always #(TA/2.0) clk_a = ~clk_a;
  always #(TB/2.0) clk_b = ~clk_b;

  mclk_gen u_mclk_gen (.clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_err(cfg_err), .mclk_out(mclk_out),
    .shclk_out(shclk_out), .mclk_valid(mclk_valid));

  int n_chk = 0, n_bad = 0, runts = 0, m_edges = 0;
  bit watching = 0, done = 0;
  realtime last_m = 0, last_s = 0;

  always @(mclk_out) begin
    if (watching && ($realtime - last_m) < MINPH - 0.001) runts++;
    last_m = $realtime;
  end
  always @(shclk_out) begin
    if (watching && ($realtime - last_s) < MINPH - 0.001) runts++;
    last_s = $realtime;
  end
  always @(posedge mclk_out) m_edges++;

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge clk_a);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk_a);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk_a);
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit shc, output real per, output real hi);
    realtime t0, t1, t2;
    if (shc) begin
      @(posedge shclk_out); @(posedge shclk_out); t0 = $realtime;
      @(negedge shclk_out); t1 = $realtime; @(posedge shclk_out); t2 = $realtime;
    end else begin
      @(posedge mclk_out); @(posedge mclk_out); t0 = $realtime;
      @(negedge mclk_out); t1 = $realtime; @(posedge mclk_out); t2 = $realtime;
    end
    per = t2 - t0; hi = t1 - t0;
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  function automatic int ratio_for(input int code);
    case (code)
      0: return 1; 2: return 2; 3: return 3; 4: return 4; default: return 6;
    endcase
  endfunction

  task automatic reconfig(input logic [7:0] v);
    wr(rd_data | 8'h01);
    wait_a(10);
    wr(v | 8'h01);
    wait_a(30);
    wr(v & 8'hFE);
    wait_a(10);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1.000 expected 0.000");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    real per, hi, tsrc, expp;
    int e0;
    wait_a(5);
    rst_n = 1'b1;
    wait_a(10);
    watching = 1;
    // R1 reset state
    check(rd_data == 8'h00, "R1", "reset register", real'(rd_data), 0.0);
    check(cfg_err == 1'b0, "R1", "reset error flag", real'(cfg_err), 0.0);
    measure(0, per, hi);
    check(near(per, TA), "R1", "reset master period", per, TA);
    measure(1, per, hi);
    check(near(per, 2.0*TA), "R1", "reset shift period", per, 2.0*TA);

    // R2 reserved bits, R8 gate off
    wr(8'h61);
    wait_a(10);
    check(rd_data == 8'h01, "R2", "reserved bits read zero", real'(rd_data), 1.0);
    e0 = m_edges;
    wait_a(20);
    check(m_edges == e0 && mclk_out == 1'b0, "R8", "edges while gated", real'(m_edges - e0), 0.0);
    check(mclk_valid == 1'b0, "R8", "valid while gated", real'(mclk_valid), 0.0);
    wr(8'h00);
    wait_a(10);
    check(mclk_valid == 1'b1, "R8", "valid after ungate", real'(mclk_valid), 1.0);
    measure(0, per, hi);
    check(near(per, TA), "R8", "period after ungate", per, TA);

    // R3 R4 R5 R7 sweep
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 6; c++) begin
        if (c == 1) continue;
        for (int d = 0; d < 2; d++) begin
          logic [7:0] v;
          v = {d[0], 2'b00, s[0], c[2:0], 1'b0};
          reconfig(v);
          tsrc = s ? TB : TA;
          expp = tsrc * ratio_for(c);
          check(rd_data == v, "R2", "register readback", real'(rd_data), real'(v));
          check(mclk_valid == 1'b1, "R3", "valid after switch", real'(mclk_valid), 1.0);
          measure(0, per, hi);
          check(near(per, expp), "R4", "master period", per, expp);
          check(near(hi, expp/2.0), "R5", "master high time", hi, expp/2.0);
          measure(1, per, hi);
          check(near(per, expp * (d ? 4.0 : 2.0)), "R7", "shift period", per, expp * (d ? 4.0 : 2.0));
        end
      end

    // R6 reserved divide codes
    reconfig(8'h06);
    check(cfg_err == 1'b0, "R6", "no error before bad code", real'(cfg_err), 0.0);
    wr(8'h02);
    wait_a(5);
    check(rd_data == 8'h06, "R6", "code kept on 001", real'(rd_data), 6.0);
    check(cfg_err == 1'b1, "R6", "error flag set", real'(cfg_err), 1.0);
    wr(8'h0C);
    wait_a(5);
    check(rd_data == 8'h06, "R6", "code kept on 110", real'(rd_data), 6.0);
    measure(0, per, hi);
    check(near(per, 3.0*TA), "R6", "ratio kept", per, 3.0*TA);
    reconfig(8'h08);
    check(cfg_err == 1'b1, "R6", "error sticky", real'(cfg_err), 1.0);

    // R9 R10 runt monitor over all switches and gating
    watching = 0;
    check(runts == 0, "R9", "short phases seen", real'(runts), 0.0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule